// File: doc/BRIEF.md
# Pipelined Bus Slave Responder

This block answers a master on a Wishbone pipelined slave port. Behind the port sits a small word-addressed register memory. A request is taken on any clock where CYC and STB are high and STALL is low. A write lands in memory on the clock it is taken, with each SEL bit enabling one byte lane. A read samples the memory on that same clock. Every accepted request gets one response: ACK, with read data for a read, or ERR when the word address lies past the end of the memory.

Responses leave in the order their requests were taken, exactly `LATENCY` clocks after acceptance. They wait in a small in-order queue of `QDEPTH` entries. Each entry carries the value of a free-running clock stamp taken when it was pushed. The queue is emptied whenever CYC is low, so a cycle the master abandons never produces a late response.

An acceptance state machine shapes STALL. It has three states:
- `ST_IDLE`: CYC is low.
- `ST_OPEN`: a request can be taken.
- `ST_HOLD`: STALL is forced high for `STALL_CYCLES` clocks after each acceptance.

It moves between them on four transitions:
- IDLE→OPEN or IDLE→HOLD when CYC rises.
- OPEN→HOLD on an acceptance.
- HOLD→OPEN when the hold count expires.
- any state→IDLE when CYC drops.

Independently of the state, STALL is raised when the queue is full and no entry leaves on the current clock.

Top module: `wbs_pipe_slave`

## Requirements
- R1: ACK and ERR are never high on the same clock, and both are low on every clock where CYC is low.
- R2: After reset, ACK, ERR and STALL are low, nothing is pending, and every memory word reads as zero.
- R3: Each accepted request produces exactly one response. That response comes exactly `LATENCY` clocks after the acceptance clock, never on the acceptance clock itself, and responses come in acceptance order, provided CYC stays high.
- R4: A read of word address `adr` below `MEM_WORDS` answers ACK with the stored word on `dat_o`. Any address at or above `MEM_WORDS` answers ERR with `dat_o` zero, and a write to such an address changes nothing.
- R5: On a write, SEL bit b enables byte lane b (data bits 8b+7 down to 8b), and lanes whose SEL bit is low keep their old value. The ACK of a write carries zero data, and `dat_o` is zero on any clock without ACK.
- R6: A cycle opens from `ST_IDLE`. When `STALL_CYCLES` is nonzero, each acceptance leads to `ST_HOLD`, where STALL stays high for exactly `STALL_CYCLES` clocks before the machine returns to `ST_OPEN`. CYC low returns the machine to `ST_IDLE` from any state.
- R7: While `QDEPTH` responses are pending and none is due on the current clock, STALL is high.
- R8: STALL never stays high together with STB for more than `STALL_CYCLES + LATENCY` consecutive clocks.
- R9: A clock with CYC low discards all pending responses, and no response ever appears without an accepted request behind it.
- R10: A request presented with STB high but CYC low is not accepted and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | Request is a write |
| adr_i | input | AW | Word address |
| dat_i | input | DW | Write data |
| sel_i | input | DW/8 | Byte lane enables |
| stall_o | output | 1 | Request not taken this clock |
| ack_o | output | 1 | Successful response |
| err_o | output | 1 | Error response (address out of range) |
| dat_o | output | DW | Read data, zero unless ACK |

## Verification
The bound checker keeps its own count of outstanding requests. From that count it checks on every clock:
- ACK and ERR never appear together.
- No response appears without an outstanding request.
- Reset clears any pending response.
- STALL rises when the queue is full, and also on the clock after every acceptance.
- Stall runs stay within their bound.

Only the bench scenarios, using the behavioural model, can show the rest:
- the exact response latency;
- response order;
- read data through partial byte-lane writes;
- ERR on out-of-range addresses;
- discarding of responses when CYC is dropped mid-flight;
- that STB with CYC low leaves memory untouched.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    // acceptance state machine encoding
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_HOLD = 2'd2
    } acc_state_t;
endpackage

// File: rtl/wbs_regfile.sv
module wbs_regfile #(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int MEM_WORDS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] wsel,
    output logic            in_range,
    output logic [DW-1:0]   rdata
);
    localparam int NBYTES = DW / 8;
    localparam int IDXW   = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;
    localparam logic [AW-1:0] LIMIT = AW'(MEM_WORDS);

    logic [IDXW-1:0] idx;

    assign in_range = (addr < LIMIT);
    assign idx      = addr[IDXW-1:0];

    // one storage array per byte lane, so SEL gates each lane separately
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [7:0] lane_mem [MEM_WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < MEM_WORDS; w++) begin
                    lane_mem[w] <= 8'h00;
                end
            end else if (wr_en && in_range && wsel[b]) begin
                lane_mem[idx] <= wdata[8*b +: 8];
            end
        end

        assign rdata[8*b +: 8] = in_range ? lane_mem[idx] : 8'h00;
    end
endmodule

// File: rtl/wbs_resp_fifo.sv
module wbs_resp_fifo #(
    parameter int DW      = 32,
    parameter int QDEPTH  = 2,
    parameter int LATENCY = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          push_err,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          head_due,
    output logic          head_err,
    output logic [DW-1:0] head_data,
    output logic          full
);
    localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CW = $clog2(QDEPTH + 1);
    localparam int TW = $clog2(LATENCY + 1) + 1;
    localparam logic [TW-1:0] LAT_T  = TW'(LATENCY);
    localparam logic [PW-1:0] LAST_P = PW'(QDEPTH - 1);

    logic          e_err   [QDEPTH];
    logic [DW-1:0] e_data  [QDEPTH];
    logic [TW-1:0] e_stamp [QDEPTH];

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [TW-1:0] now;
    logic [TW-1:0] age;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else begin
            now <= now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                e_err[wr_ptr]   <= push_err;
                e_data[wr_ptr]  <= push_data;
                e_stamp[wr_ptr] <= now;
                wr_ptr          <= step_ptr(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // modular age is exact because the head leaves as soon as it reaches LATENCY
    assign age       = now - e_stamp[rd_ptr];
    assign head_due  = (count != '0) && (age == LAT_T);
    assign head_err  = e_err[rd_ptr];
    assign head_data = e_data[rd_ptr];
    assign full      = (count == CW'(QDEPTH));
endmodule

// File: rtl/wbs_accept_fsm.sv
module wbs_accept_fsm
    import wbs_pkg::*;
#(
    parameter int STALL_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    input  logic queue_block,
    output logic stall,
    output logic accept
);
    localparam int  SW       = (STALL_CYCLES > 1) ? $clog2(STALL_CYCLES) : 1;
    localparam bit  HAS_HOLD = (STALL_CYCLES > 0);
    localparam logic [SW-1:0] LAST_C = SW'((STALL_CYCLES > 0) ? STALL_CYCLES - 1 : 0);

    acc_state_t    state, nxt;
    logic [SW-1:0] hold_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
        end else begin
            state    <= nxt;
            hold_cnt <= (state == ST_HOLD) ? hold_cnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        stall  = cyc && ((state == ST_HOLD) || queue_block);
        accept = cyc && stb && !stall;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cyc) begin
                    nxt = (accept && HAS_HOLD) ? ST_HOLD : ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (!cyc) begin
                    nxt = ST_IDLE;
                end else if (accept && HAS_HOLD) begin
                    nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!cyc) begin
                    nxt = ST_IDLE;
                end else if (hold_cnt == LAST_C) begin
                    nxt = ST_OPEN;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wbs_pipe_slave.sv
module wbs_pipe_slave #(
    parameter int AW           = 8,
    parameter int DW           = 32,
    parameter int MEM_WORDS    = 16,
    parameter int STALL_CYCLES = 1,
    parameter int LATENCY      = 5,
    parameter int QDEPTH       = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            cyc_i,
    input  logic            stb_i,
    input  logic            we_i,
    input  logic [AW-1:0]   adr_i,
    input  logic [DW-1:0]   dat_i,
    input  logic [DW/8-1:0] sel_i,
    output logic            stall_o,
    output logic            ack_o,
    output logic            err_o,
    output logic [DW-1:0]   dat_o
);
    logic          accept;
    logic          in_range;
    logic [DW-1:0] rdata;
    logic          head_due, head_err, full;
    logic [DW-1:0] head_data;
    logic          pop;
    logic          queue_block;

    assign pop         = cyc_i && head_due;
    assign queue_block = full && !pop;

    wbs_accept_fsm #(
        .STALL_CYCLES(STALL_CYCLES)
    ) u_fsm (
        .clk        (clk_i),
        .rst        (rst_i),
        .cyc        (cyc_i),
        .stb        (stb_i),
        .queue_block(queue_block),
        .stall      (stall_o),
        .accept     (accept)
    );

    wbs_regfile #(
        .AW       (AW),
        .DW       (DW),
        .MEM_WORDS(MEM_WORDS)
    ) u_mem (
        .clk     (clk_i),
        .rst     (rst_i),
        .addr    (adr_i),
        .wr_en   (accept && we_i),
        .wdata   (dat_i),
        .wsel    (sel_i),
        .in_range(in_range),
        .rdata   (rdata)
    );

    wbs_resp_fifo #(
        .DW     (DW),
        .QDEPTH (QDEPTH),
        .LATENCY(LATENCY)
    ) u_queue (
        .clk      (clk_i),
        .rst      (rst_i),
        .flush    (!cyc_i),
        .push     (accept),
        .push_err (!in_range),
        .push_data((we_i || !in_range) ? '0 : rdata),
        .pop      (pop),
        .head_due (head_due),
        .head_err (head_err),
        .head_data(head_data),
        .full     (full)
    );

    assign ack_o = pop && !head_err;
    assign err_o = pop && head_err;
    assign dat_o = ack_o ? head_data : '0;
endmodule

// File: rtl/wbs_pipe_slave_chk.sv
module wbs_pipe_slave_chk #(
    parameter int QDEPTH       = 2,
    parameter int STALL_CYCLES = 1,
    parameter int LATENCY      = 5
) (
    input logic clk_i,
    input logic rst_i,
    input logic cyc_i,
    input logic stb_i,
    input logic stall_o,
    input logic ack_o,
    input logic err_o
);
    localparam int BOUND = STALL_CYCLES + LATENCY;

    logic       took;
    logic       resp;
    logic [7:0] outst;
    logic [15:0] stall_run;

    assign took = cyc_i && stb_i && !stall_o;
    assign resp = ack_o || err_o;

    always_ff @(posedge clk_i) begin
        if (rst_i || !cyc_i) begin
            outst <= '0;
        end else begin
            outst <= outst + 8'(took) - 8'(resp);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !(cyc_i && stb_i && stall_o)) begin
            stall_run <= '0;
        end else begin
            stall_run <= stall_run + 1'b1;
        end
    end

    // R1
    a_r1_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ack_o && err_o));

    // R2
    a_r2_reset_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!ack_o && !err_o));

    // R9
    a_r9_matched: assert property (@(posedge clk_i) disable iff (rst_i)
        resp |-> (outst != 8'd0));

    // R7
    a_r7_full_stall: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_i && (outst == 8'(QDEPTH)) && !resp) |-> stall_o);

    // R8
    a_r8_stall_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_i && stb_i && stall_o) |-> (stall_run < 16'(BOUND)));

    if (STALL_CYCLES > 0) begin : g_hold
        // R6
        a_r6_hold_after_take: assert property (@(posedge clk_i) disable iff (rst_i)
            ($past(took) && !$past(rst_i) && cyc_i) |-> stall_o);
    end
endmodule

bind wbs_pipe_slave wbs_pipe_slave_chk #(
    .QDEPTH      (QDEPTH),
    .STALL_CYCLES(STALL_CYCLES),
    .LATENCY     (LATENCY)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cyc_i  (cyc_i),
    .stb_i  (stb_i),
    .stall_o(stall_o),
    .ack_o  (ack_o),
    .err_o  (err_o)
);

// File: tb/wbs_pipe_slave_tb.sv
`timescale 1ns/100ps
module wbs_pipe_slave_tb;
    localparam int AW = 8, DW = 32, MEM_WORDS = 16;
    localparam int STALL_CYCLES = 1, LATENCY = 5, QDEPTH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [AW-1:0] adr = '0;
    logic [DW-1:0] wdat = '0;
    logic [3:0]    sel = '0;
    logic stall, ack, err;
    logic [DW-1:0] rdat;

    always #2.5 clk = ~clk;

    wbs_pipe_slave #(
        .AW(AW), .DW(DW), .MEM_WORDS(MEM_WORDS),
        .STALL_CYCLES(STALL_CYCLES), .LATENCY(LATENCY), .QDEPTH(QDEPTH)
    ) u_dut (
        .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wdat), .sel_i(sel),
        .stall_o(stall), .ack_o(ack), .err_o(err), .dat_o(rdat)
    );

    // behavioural reference model
    logic [31:0] mem_m [MEM_WORDS];
    logic        q_err  [$];
    logic [31:0] q_data [$];
    int          q_due  [$];
    int now_c = 0;
    int hold_left = 0;
    int n_cmp = 0, n_bad = 0;
    int run = 0, max_run = 0;
    string tag = "R2";

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic c, input logic s, input logic w, input logic [7:0] a,
                         input logic [31:0] d, input logic [3:0] sl, output bit acc);
        bit pop, fullq, e_stall;
        logic [31:0] nd;
        @(negedge clk);
        cyc = c; stb = s; we = w; adr = a; wdat = d; sel = sl;
        #1;
        pop     = c && (q_due.size() > 0) && (q_due[0] == now_c);
        fullq   = (q_due.size() == QDEPTH);
        e_stall = c && ((hold_left > 0) || (fullq && !pop));
        chk(hold_left > 0 ? "R6 stall" : "R7 stall", 32'(stall), 32'(e_stall));
        chk("R3 ack", 32'(ack), 32'(pop && !q_err[0]));
        chk("R4 err", 32'(err), 32'(pop && q_err[0]));
        chk("R5 data", rdat, (pop && !q_err[0]) ? q_data[0] : 32'h0);
        chk("R1 excl", 32'(ack && err), 32'h0);
        if (c && s && stall) run++; else run = 0;
        if (run > max_run) max_run = run;
        acc = c && s && !e_stall;
        if (!c) begin
            q_err.delete(); q_data.delete(); q_due.delete();
            hold_left = 0;
        end else begin
            if (pop) begin
                void'(q_err.pop_front()); void'(q_data.pop_front()); void'(q_due.pop_front());
            end
            if (acc) begin
                if (a < MEM_WORDS) begin
                    q_err.push_back(1'b0);
                    q_data.push_back(w ? 32'h0 : mem_m[a]);
                    if (w) begin
                        nd = mem_m[a];
                        for (int b = 0; b < 4; b++) if (sl[b]) nd[8*b +: 8] = d[8*b +: 8];
                        mem_m[a] = nd;
                    end
                end else begin
                    q_err.push_back(1'b1);
                    q_data.push_back(32'h0);
                end
                q_due.push_back(now_c + LATENCY);
                hold_left = STALL_CYCLES;
            end else if (hold_left > 0) begin
                hold_left--;
            end
        end
        now_c++;
    endtask

    task automatic req(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] sl);
        bit acc;
        acc = 1'b0;
        while (!acc) cycle(1'b1, 1'b1, w, a, d, sl, acc);
    endtask

    task automatic idle(input int n, input logic c);
        bit acc;
        for (int i = 0; i < n; i++) cycle(c, 1'b0, 1'b0, 8'h0, 32'h0, 4'h0, acc);
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit acc;
        logic [15:0] lf;
        for (int w = 0; w < MEM_WORDS; w++) mem_m[w] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        tag = "R2";
        chk("ack after reset", 32'(ack), 32'h0);
        chk("err after reset", 32'(err), 32'h0);
        chk("stall after reset", 32'(stall), 32'h0);
        idle(2, 1'b0);
        // R2: memory reads zero
        req(1'b0, 8'd3, 32'h0, 4'hf);
        idle(LATENCY + 1, 1'b1);

        // R5 and R7: pipelined full writes, then a masked write, then reads
        tag = "R5";
        for (int i = 0; i < 4; i++) req(1'b1, 8'(i), 32'h1111_1111 * (i + 1), 4'hf);
        req(1'b1, 8'd1, 32'hAABB_CCDD, 4'b0101);
        req(1'b1, 8'd2, 32'h9988_7766, 4'b1000);
        tag = "R7";
        for (int i = 0; i < 4; i++) req(1'b0, 8'(i), 32'h0, 4'hf);
        idle(LATENCY + 1, 1'b1);

        // R4: out-of-range read and write
        tag = "R4";
        req(1'b0, 8'd20, 32'h0, 4'hf);
        req(1'b1, 8'd200, 32'hDEAD_BEEF, 4'hf);
        req(1'b0, 8'd15, 32'h0, 4'hf);
        idle(LATENCY + 1, 1'b1);

        // R9: drop CYC with responses in flight
        tag = "R9";
        req(1'b0, 8'd1, 32'h0, 4'hf);
        req(1'b0, 8'd2, 32'h0, 4'hf);
        idle(1, 1'b0);
        idle(LATENCY + 2, 1'b1);
        req(1'b0, 8'd0, 32'h0, 4'hf);
        idle(LATENCY + 1, 1'b1);

        // R10: STB with CYC low is ignored, then read back
        tag = "R10";
        cycle(1'b0, 1'b1, 1'b1, 8'd2, 32'h0BAD_0BAD, 4'hf, acc);
        chk("no accept with cyc low", 32'(acc), 32'h0);
        cycle(1'b0, 1'b1, 1'b1, 8'd2, 32'h0BAD_0BAD, 4'hf, acc);
        req(1'b0, 8'd2, 32'h0, 4'hf);
        idle(LATENCY + 1, 1'b1);

        // R3 and R6: mixed pipelined traffic with gaps
        tag = "R3";
        lf = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[1:0] == 2'b00) idle(1, 1'b1);
            req(lf[9], 8'(lf[7:4]) + (lf[8] ? 8'd4 : 8'd0), {lf, lf ^ 16'h5A5A}, lf[13:10]);
        end
        idle(LATENCY + 2, 1'b1);
        for (int i = 0; i < MEM_WORDS; i++) req(1'b0, 8'(i), 32'h0, 4'hf);
        idle(LATENCY + 2, 1'b1);
        idle(2, 1'b0);

        tag = "R8";
        chk("longest stall run within bound", 32'(max_run <= STALL_CYCLES + LATENCY), 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule